// File: doc/BRIEF.md
# Packet DMA Channel Register Block

This block is the host-visible register window of one channel in a two-channel DMA engine that executes command packets. A simple memory-mapped bus writes and reads the channel's control word, its event status byte, the packet count, the pointer to the next command packet and the two FIFO thresholds. The block turns a start request in the control word into a single-cycle start pulse toward the packet engine, and holds the engine in reset while the control word's reset bit is set. The engine reports abort, unexpected-interrupt and bus-error events back. These events latch into the status byte and raise an interrupt unless the interrupt is masked.

Starting a packet is guarded by a global arming byte. The host must first write the key value 7 to the global byte address 0xC7. Until then, start requests are dropped. The arming is sticky until the block is reset. Each instance serves one channel. Its window base is 0x80 plus 0x20 times the channel number, so two instances with channel numbers 0 and 1 share one bus.

Top module: `dch_regs_top`

## Requirements
- R1: After a synchronous active-low reset, the control word, status byte, packet count, next pointer, both thresholds and the arming flag are all zero, and go_pulse and irq are low.
- R2: A write to window offset 0x00 stores bit 8 (interrupt mask, 1 = masked), bit 5 (engine reset) and bits 1:0 (PIO mode). A read of offset 0x00 returns those bits in the same positions, and reads every other bit, including bit 7, as 0. pio_mode shows bits 1:0.
- R3: A control write with bit 7 set, while armed and with bit 5 clear in both the written value and the stored control word, makes go_pulse high for exactly the one cycle after the write.
- R4: A control write with bit 7 set produces no go_pulse if the block is not armed, if the written bit 5 is 1, or if the stored reset bit is 1.
- R5: Writing 0x07 to byte address 0xC7 arms the block. Writing any other value there has no effect. Once armed, the block stays armed until reset.
- R6: Status bits 6 (abort), 4 (unexpected interrupt) and 0 (bus error) are set by ev_abort, ev_unexp and ev_buserr respectively. Each bit stays set until the status byte is read.
- R7: A read of offset 0x02 returns the status byte and clears all its bits at the end of that cycle. An event arriving in the same cycle as the read remains set afterwards.
- R8: irq is high exactly when any status bit is set and the mask bit is 0.
- R9: The packet count (offset 0x04, 16 bits), next pointer (offset 0x0C, 32 bits), in-FIFO threshold (offset 0x14, 16 bits) and out-FIFO threshold (offset 0x16, 16 bits) store write data and read it back. Their values also appear on their output ports.
- R10: Accesses outside this channel's window, other than the arming byte, change no register and read as 0.
- R11: eng_reset equals the stored control reset bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd, 0 otherwise |
| ev_abort | input | 1 | Engine abort event |
| ev_unexp | input | 1 | Engine unexpected-interrupt event |
| ev_buserr | input | 1 | Engine bus/parity error event |
| go_pulse | output | 1 | Single-cycle packet start to the engine |
| eng_reset | output | 1 | Engine reset level |
| pio_mode | output | 2 | PIO mode field |
| cpb_count | output | 16 | Packet count |
| cpb_next | output | 32 | Next packet pointer |
| fifo_in_thr | output | 16 | Input FIFO threshold |
| fifo_out_thr | output | 16 | Output FIFO threshold |
| irq | output | 1 | Interrupt request |

## Verification
A wrong arming flag or a stale stored reset bit shows up in the cycle after a control write: go_pulse either appears when it should not or fails to appear. A status byte that misses an event or loses one at a read shows up on irq in the next cycle, and on the read data at the following status read. Configuration registers are observed on their output ports one cycle after each write. Accesses aimed at the other channel's window must leave every one of those ports unchanged.

// File: rtl/dch_pkg.sv
// Shared offsets, bit positions and decode type for the channel register block.
package dch_pkg;
    localparam int OFF_CTRL = 'h00;
    localparam int OFF_STAT = 'h02;
    localparam int OFF_CNT  = 'h04;
    localparam int OFF_NEXT = 'h0C;
    localparam int OFF_FIN  = 'h14;
    localparam int OFF_FOUT = 'h16;

    localparam int B_MASK = 8;
    localparam int B_GO   = 7;
    localparam int B_RST  = 5;

    localparam int S_ABORT  = 6;
    localparam int S_UNEXP  = 4;
    localparam int S_BUSERR = 0;

    typedef struct packed {
        logic ctrl;
        logic stat;
        logic cnt;
        logic nxt;
        logic fin;
        logic fout;
        logic lock;
    } hit_t;
endpackage

// File: rtl/dch_decode.sv
// Address decoder: flags which register of this channel, or the global arming
// byte, the current bus address selects. Assumes byte addresses and a window
// stride that is a power of two.
module dch_decode
    import dch_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int CHAN_ID    = 0,
    parameter int WIN_BASE   = 'h80,
    parameter int WIN_STRIDE = 'h20,
    parameter int LOCK_ADDR  = 'hC7
) (
    input  logic [ADDR_W-1:0] addr,
    output hit_t              hit
);
    localparam int OFF_W = $clog2(WIN_STRIDE);
    localparam logic [ADDR_W-1:0] CHAN_BASE = ADDR_W'(WIN_BASE + CHAN_ID * WIN_STRIDE);
    localparam logic [ADDR_W-1:0] LOCK_A    = ADDR_W'(LOCK_ADDR);

    logic             in_win;
    logic [OFF_W-1:0] off;

    // Split the address into window match and offset inside the window.
    always_comb begin
        in_win = (addr[ADDR_W-1:OFF_W] == CHAN_BASE[ADDR_W-1:OFF_W]);
        off    = addr[OFF_W-1:0];
    end

    // One select line per register.
    always_comb begin
        hit.ctrl = in_win && (off == OFF_W'(OFF_CTRL));
        hit.stat = in_win && (off == OFF_W'(OFF_STAT));
        hit.cnt  = in_win && (off == OFF_W'(OFF_CNT));
        hit.nxt  = in_win && (off == OFF_W'(OFF_NEXT));
        hit.fin  = in_win && (off == OFF_W'(OFF_FIN));
        hit.fout = in_win && (off == OFF_W'(OFF_FOUT));
        hit.lock = (addr == LOCK_A);
    end
endmodule

// File: rtl/dch_ctrl.sv
// Control word, arming flag and start pulse. A start request is honoured only
// when armed and when neither the written nor the stored reset bit is set.
module dch_ctrl
    import dch_pkg::*;
#(
    parameter int PIO_W    = 2,
    parameter int LOCK_KEY = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_ctrl,
    input  logic        wr_lock,
    input  logic [15:0] wdata,
    output logic        mask,
    output logic        rst_bit,
    output logic [PIO_W-1:0] pio,
    output logic        armed,
    output logic        go
);
    logic go_req;

    // Decide whether this write carries an accepted start request.
    always_comb begin
        go_req = wr_ctrl && wdata[B_GO] && armed && !wdata[B_RST] && !rst_bit;
    end

    // Store the control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask    <= 1'b0;
            rst_bit <= 1'b0;
            pio     <= '0;
        end else if (wr_ctrl) begin
            mask    <= wdata[B_MASK];
            rst_bit <= wdata[B_RST];
            pio     <= wdata[PIO_W-1:0];
        end
    end

    // Sticky arming flag, set only by the key value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (wr_lock && (wdata[7:0] == 8'(LOCK_KEY)))
            armed <= 1'b1;
    end

    // Register the start pulse so it lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            go <= 1'b0;
        else
            go <= go_req;
    end
endmodule

// File: rtl/dch_status.sv
// Sticky event status byte. A read clears it; events in the read cycle survive.
module dch_status #(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [STAT_W-1:0] events,
    output logic [STAT_W-1:0] status
);
    // Latch events, clearing on a read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else
            status <= (clr ? '0 : status) | events;
    end
endmodule

// File: rtl/dch_field.sv
// Plain loadable configuration register of parameter width.
module dch_field #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Load on a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/dch_regs_top.sv
// Register window of one packet-DMA channel. Assumes one access per cycle, with
// bus_wr and bus_rd never both high. Read data is combinational in the read
// cycle.
module dch_regs_top
    import dch_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int CHAN_ID = 0,
    parameter int CNT_W   = 16,
    parameter int PTR_W   = 32,
    parameter int THR_W   = 16,
    parameter int PIO_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ev_abort,
    input  logic              ev_unexp,
    input  logic              ev_buserr,
    output logic              go_pulse,
    output logic              eng_reset,
    output logic [PIO_W-1:0]  pio_mode,
    output logic [CNT_W-1:0]  cpb_count,
    output logic [PTR_W-1:0]  cpb_next,
    output logic [THR_W-1:0]  fifo_in_thr,
    output logic [THR_W-1:0]  fifo_out_thr,
    output logic              irq
);
    localparam int STAT_W = 8;

    hit_t              hit;
    logic              ctrl_mask;
    logic              lock_q;
    logic              stat_rd;
    logic [STAT_W-1:0] status_q;
    logic [STAT_W-1:0] ev_vec;

    dch_decode #(.ADDR_W(ADDR_W), .CHAN_ID(CHAN_ID)) u_dec (
        .addr (bus_addr),
        .hit  (hit)
    );

    dch_ctrl #(.PIO_W(PIO_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (bus_wr && hit.ctrl),
        .wr_lock (bus_wr && hit.lock),
        .wdata   (bus_wdata[15:0]),
        .mask    (ctrl_mask),
        .rst_bit (eng_reset),
        .pio     (pio_mode),
        .armed   (lock_q),
        .go      (go_pulse)
    );

    // Place engine events on their status bit positions.
    always_comb begin
        ev_vec           = '0;
        ev_vec[S_ABORT]  = ev_abort;
        ev_vec[S_UNEXP]  = ev_unexp;
        ev_vec[S_BUSERR] = ev_buserr;
        stat_rd          = bus_rd && hit.stat;
    end

    dch_status #(.STAT_W(STAT_W)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (stat_rd),
        .events (ev_vec),
        .status (status_q)
    );

    dch_field #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(bus_wr && hit.cnt),
        .d(bus_wdata[CNT_W-1:0]), .q(cpb_count)
    );
    dch_field #(.W(PTR_W)) u_nxt (
        .clk(clk), .rst_n(rst_n), .load(bus_wr && hit.nxt),
        .d(bus_wdata[PTR_W-1:0]), .q(cpb_next)
    );
    dch_field #(.W(THR_W)) u_fin (
        .clk(clk), .rst_n(rst_n), .load(bus_wr && hit.fin),
        .d(bus_wdata[THR_W-1:0]), .q(fifo_in_thr)
    );
    dch_field #(.W(THR_W)) u_fout (
        .clk(clk), .rst_n(rst_n), .load(bus_wr && hit.fout),
        .d(bus_wdata[THR_W-1:0]), .q(fifo_out_thr)
    );

    // Interrupt: any pending status bit, unless masked.
    always_comb begin
        irq = (|status_q) && !ctrl_mask;
    end

    // Read multiplexer, zero when not reading or when no register is selected.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (hit.ctrl) begin
                bus_rdata[B_MASK]    = ctrl_mask;
                bus_rdata[B_RST]     = eng_reset;
                bus_rdata[PIO_W-1:0] = pio_mode;
            end else if (hit.stat) begin
                bus_rdata[STAT_W-1:0] = status_q;
            end else if (hit.cnt) begin
                bus_rdata[CNT_W-1:0] = cpb_count;
            end else if (hit.nxt) begin
                bus_rdata[PTR_W-1:0] = cpb_next;
            end else if (hit.fin) begin
                bus_rdata[THR_W-1:0] = fifo_in_thr;
            end else if (hit.fout) begin
                bus_rdata[THR_W-1:0] = fifo_out_thr;
            end
        end
    end
endmodule

// File: rtl/dch_regs_chk.sv
// Temporal checks on the channel register block, bound to every instance.
module dch_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       go_pulse,
    input logic       eng_reset,
    input logic       irq,
    input logic       mask,
    input logic       lock,
    input logic [7:0] status,
    input logic       stat_rd,
    input logic       ev_buserr
);
    AST_GO_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        go_pulse |-> $past(bus_wr)); // R3
    AST_GO_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        go_pulse |-> lock); // R4
    AST_GO_OUT_OF_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        go_pulse |-> !eng_reset); // R4
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock); // R5
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((status & $past(status)) == $past(status))); // R6
    AST_EVENT_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
        ev_buserr |=> status[0]); // R7
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        mask |-> !irq); // R8
    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != 8'h00)); // R8
endmodule

bind dch_regs_top dch_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .go_pulse  (go_pulse),
    .eng_reset (eng_reset),
    .irq       (irq),
    .mask      (ctrl_mask),
    .lock      (lock_q),
    .status    (status_q),
    .stat_rd   (stat_rd),
    .ev_buserr (ev_buserr)
);

// File: tb/tb_dch_regs_top.sv
// Bench: behavioural reference model stepped every clock and compared.
module tb_dch_regs_top;
    logic        clk = 1'b0;
    logic        rst_n, bus_wr, bus_rd;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        ev_abort, ev_unexp, ev_buserr;
    logic        go_pulse, eng_reset, irq;
    logic [1:0]  pio_mode;
    logic [15:0] cpb_count, fifo_in_thr, fifo_out_thr;
    logic [31:0] cpb_next;

    always #5 clk = ~clk;

    dch_regs_top dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_abort(ev_abort), .ev_unexp(ev_unexp), .ev_buserr(ev_buserr),
        .go_pulse(go_pulse), .eng_reset(eng_reset), .pio_mode(pio_mode),
        .cpb_count(cpb_count), .cpb_next(cpb_next), .fifo_in_thr(fifo_in_thr),
        .fifo_out_thr(fifo_out_thr), .irq(irq)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // Reference model state.
    logic        m_mask, m_rst, m_lock, m_go;
    logic [1:0]  m_pio;
    logic [7:0]  m_stat;
    logic [15:0] m_cnt, m_fin, m_fout;
    logic [31:0] m_next;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_rd(input logic [7:0] a);
        case (a)
            8'h80:   return {23'b0, m_mask, 2'b0, m_rst, 3'b0, m_pio};
            8'h82:   return {24'b0, m_stat};
            8'h84:   return {16'b0, m_cnt};
            8'h8C:   return m_next;
            8'h94:   return {16'b0, m_fin};
            8'h96:   return {16'b0, m_fout};
            default: return 32'h0;
        endcase
    endfunction

    // One bus cycle: drive, check read data, step the model, check outputs.
    task automatic cyc(input bit rst, input bit wr, input bit rd, input logic [7:0] a,
                       input logic [31:0] d, input logic [2:0] ev);
        logic [31:0] exp_rd;
        string       tag;
        logic        ngo;
        logic [7:0]  nstat;
        rst_n = !rst; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        {ev_abort, ev_unexp, ev_buserr} = ev;
        #1;
        exp_rd = (rd && !rst) ? model_rd(a) : 32'h0;
        if (a == 8'h80)               tag = "R2";
        else if (a == 8'h82)          tag = "R6 R7";
        else if (a[7:5] == 3'b100)    tag = "R9";
        else                          tag = "R10";
        if (!rst) chk(bus_rdata === exp_rd, tag, bus_rdata, exp_rd);
        @(posedge clk);
        if (rst) begin
            m_mask = 0; m_rst = 0; m_lock = 0; m_go = 0; m_pio = 0;
            m_stat = 0; m_cnt = 0; m_fin = 0; m_fout = 0; m_next = 0;
        end else begin
            ngo   = wr && a == 8'h80 && d[7] && m_lock && !d[5] && !m_rst;
            nstat = ((rd && a == 8'h82) ? 8'h00 : m_stat) | {1'b0, ev[2], 1'b0, ev[1], 3'b0, ev[0]};
            if (wr) begin
                case (a)
                    8'h80: begin m_mask = d[8]; m_rst = d[5]; m_pio = d[1:0]; end
                    8'h84: m_cnt  = d[15:0];
                    8'h8C: m_next = d;
                    8'h94: m_fin  = d[15:0];
                    8'h96: m_fout = d[15:0];
                    8'hC7: if (d[7:0] == 8'h07) m_lock = 1'b1;
                    default: ;
                endcase
            end
            m_go = ngo; m_stat = nstat;
        end
        @(negedge clk);
        if (rst_n) begin
            chk(go_pulse === m_go, "R3", 32'(go_pulse), 32'(m_go));
            chk(eng_reset === m_rst, "R11", 32'(eng_reset), 32'(m_rst));
            chk(pio_mode === m_pio, "R2", 32'(pio_mode), 32'(m_pio));
            chk(irq === ((m_stat != 0) && !m_mask), "R8", 32'(irq), 32'((m_stat != 0) && !m_mask));
            chk(cpb_count === m_cnt, "R9", 32'(cpb_count), 32'(m_cnt));
            chk(cpb_next === m_next, "R9", cpb_next, m_next);
            chk(fifo_in_thr === m_fin, "R9", 32'(fifo_in_thr), 32'(m_fin));
            chk(fifo_out_thr === m_fout, "R9", 32'(fifo_out_thr), 32'(m_fout));
        end
    endtask

    task automatic idle(); cyc(0, 0, 0, 8'h00, 0, 3'b000); endtask
    task automatic wr(input logic [7:0] a, input logic [31:0] d); cyc(0, 1, 0, a, d, 3'b000); endtask
    task automatic rd(input logic [7:0] a); cyc(0, 0, 1, a, 0, 3'b000); endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 8'h00, 0, 3'b000);
        idle();
        // R1: reset state visible at the ports and through reads
        chk({go_pulse, irq, eng_reset, pio_mode} === 5'b0, "R1", 32'({go_pulse, irq, eng_reset, pio_mode}), 0);
        chk({cpb_count, fifo_in_thr, fifo_out_thr} === 48'b0 && cpb_next === 0, "R1", cpb_next, 0);
        rd(8'h80); rd(8'h82); rd(8'h84); rd(8'h8C); rd(8'h94); rd(8'h96);

        // R4: start request before arming is dropped
        wr(8'h80, 32'h0083);
        chk(go_pulse === 1'b0, "R4", 32'(go_pulse), 0);
        rd(8'h80);
        // R5: wrong key does not arm
        wr(8'hC7, 32'h0000_0005);
        wr(8'h80, 32'h0083);
        chk(go_pulse === 1'b0, "R5", 32'(go_pulse), 0);
        // R5: correct key arms; R3 pulse lasts one cycle
        wr(8'hC7, 32'h0000_0007);
        wr(8'h80, 32'h0083);
        chk(go_pulse === 1'b1, "R3", 32'(go_pulse), 1);
        idle();
        chk(go_pulse === 1'b0, "R3", 32'(go_pulse), 0);
        // R4: reset bit in written value, then stored reset bit, both block go
        wr(8'h80, 32'h00A3);
        chk(go_pulse === 1'b0 && eng_reset === 1'b1, "R4", 32'({go_pulse, eng_reset}), 32'b01);
        rd(8'h80);
        wr(8'h80, 32'h0083);
        chk(go_pulse === 1'b0 && eng_reset === 1'b0, "R4", 32'({go_pulse, eng_reset}), 0);
        wr(8'h80, 32'h0083);
        chk(go_pulse === 1'b1, "R3", 32'(go_pulse), 1);
        // R5: later non-key write keeps the block armed
        wr(8'hC7, 32'h0000_0000);
        wr(8'h80, 32'h0082);
        chk(go_pulse === 1'b1, "R5", 32'(go_pulse), 1);
        // back-to-back start requests
        wr(8'h80, 32'h0081);
        wr(8'h80, 32'h0003);

        // R9: configuration registers
        wr(8'h84, 32'hFFFF_0001);
        wr(8'h8C, 32'hDEAD_BEE8);
        wr(8'h94, 32'h0000_0100);
        wr(8'h96, 32'h0000_0100);
        rd(8'h84); rd(8'h8C); rd(8'h94); rd(8'h96);
        wr(8'h96, 32'h0000_A5C3);
        rd(8'h96);

        // R10: other channel window and unmapped offsets do nothing
        wr(8'hA4, 32'h0000_1234);
        chk(cpb_count === 16'h0001, "R10", 32'(cpb_count), 32'h1);
        wr(8'hA0, 32'h0000_0123);
        chk(pio_mode === 2'b11 && eng_reset === 1'b0, "R10", 32'({eng_reset, pio_mode}), 32'h3);
        wr(8'h90, 32'hFFFF_FFFF);
        rd(8'hA4); rd(8'h90); rd(8'hC7);

        // R6/R7/R8: events, masking, read-clear
        cyc(0, 0, 0, 8'h00, 0, 3'b010);
        chk(irq === 1'b1, "R8", 32'(irq), 1);
        cyc(0, 0, 0, 8'h00, 0, 3'b100);
        idle();
        chk(irq === 1'b1, "R6", 32'(irq), 1);
        wr(8'h80, 32'h0103);
        chk(irq === 1'b0, "R8", 32'(irq), 0);
        rd(8'h82);
        rd(8'h82);
        cyc(0, 0, 0, 8'h00, 0, 3'b001);
        cyc(0, 0, 1, 8'h82, 0, 3'b001);
        rd(8'h82);
        rd(8'h82);
        wr(8'h80, 32'h0003);
        cyc(0, 0, 1, 8'h82, 0, 3'b111);
        chk(irq === 1'b1, "R7", 32'(irq), 1);
        rd(8'h82);
        chk(irq === 1'b0, "R7", 32'(irq), 0);

        // R1: mid-run reset clears everything, including arming
        cyc(0, 0, 0, 8'h00, 0, 3'b100);
        cyc(1, 0, 0, 8'h00, 0, 3'b000);
        idle();
        chk(irq === 1'b0 && cpb_next === 0 && fifo_in_thr === 0, "R1", cpb_next, 0);
        wr(8'h80, 32'h0083);
        chk(go_pulse === 1'b0, "R5", 32'(go_pulse), 0);
        idle();
        finish_run();
    end
endmodule